// File: doc/BRIEF.md
# Burst SRAM Address Sequencer

This block produces the four addresses of one burst on a synchronous burst memory. A load strobe captures a full start address from outside. Each advance strobe then steps to the next address. Only the two lowest address bits change during a burst. Every bit above them keeps the loaded value until the next load.

Two step orders are offered. The interleaved order forms the low bits as the start offset XOR the beat count. The linear order adds the beat count to the start offset, modulo 4. A static order input selects between them and is captured at load time. After the fourth beat, a further advance returns to the start offset and the cycle repeats in the same order.

The outputs are the current address, a two-bit beat index and a last-beat flag. The interface carries no data stream, so it uses plain strobes with no valid/ready handshake and no back-pressure. The block accepts one strobe per cycle and never stalls the caller.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears its state. After that edge, `addr_o` is 0, `beat_o` is 0 and `last_o` is 0. With no load after reset, advances follow the interleaved order from offset 0.
- R2: A clock edge with `load_i` high captures `addr_i` whole. From the following cycle, `addr_o` equals the captured address and `beat_o` is 0.
- R3: When `load_i` and `adv_i` are both high at the same edge, the load takes effect and the advance is ignored, so `beat_o` is 0 afterwards.
- R4: A clock edge with `adv_i` high and `load_i` low increments `beat_o` by one, modulo 4. `last_o` is 1 exactly when `beat_o` is 3.
- R5: If `mode_i` was 1 at the last load (interleaved order), then `addr_o[1:0]` equals the loaded offset XOR `beat_o`. For example, offset 01 gives 01, 00, 11, 10.
- R6: If `mode_i` was 0 at the last load (linear order), then `addr_o[1:0]` equals the loaded offset plus `beat_o`, modulo 4. For example, offset 11 gives 11, 00, 01, 10.
- R7: An advance from beat 3 returns `addr_o` to the loaded start address and `beat_o` to 0. Later advances repeat the same four addresses.
- R8: Between loads, `addr_o[AW-1:2]` stays equal to the loaded upper bits.
- R9: A clock edge with both `load_i` and `adv_i` low leaves `addr_o`, `beat_o` and `last_o` unchanged.
- R10: Changing `mode_i` while no load is made has no effect on the order of the burst in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Capture `addr_i` as the start of a new burst |
| adv_i | input | 1 | Step to the next burst address |
| addr_i | input | AW | External start address |
| mode_i | input | 1 | Order select: 1 interleaved, 0 linear |
| addr_o | output | AW | Current burst address |
| beat_o | output | 2 | Position within the burst, 0 to 3 |
| last_o | output | 1 | High on beat 3 |

## Verification
The bench sweeps all four start offsets in both orders. It advances eight times from each start, so every sequence wraps and repeats. An order-select bug would show up as a linear sequence where an interleaved one was expected, or the reverse. An off-by-one in the wrap would return to offset 0 instead of the start offset. The bench also drives load and advance together: a design that let the advance win would report beat 1 after the load. A mode change in mid-burst would bend the order if the mode were read live instead of latched. A carry leaking out of the low bits would disturb the upper address. Idle cycles catch a design that drifts without a strobe.

// File: rtl/bas_pkg.sv
package bas_pkg;
  localparam int BEAT_W = 2;
  localparam int BEATS  = 1 << BEAT_W;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

  typedef logic [BEAT_W-1:0] beat_t;
endpackage

// File: rtl/bas_capture.sv
module bas_capture
  import bas_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [AW-1:0]     addr_in,
  input  logic              mode_in,
  output logic [AW-1:0]     start_q,
  output order_e            order_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      order_q <= ORD_INTERLEAVE;
    end else if (load) begin
      start_q <= addr_in;
      order_q <= order_e'(mode_in);
    end
  end
endmodule

// File: rtl/bas_beat_ctr.sv
module bas_beat_ctr
  import bas_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  clear,
  input  logic  step,
  output beat_t beat_q
);
  always_ff @(posedge clk) begin
    if (rst || clear) beat_q <= '0;
    else if (step)    beat_q <= beat_q + beat_t'(1);
  end
endmodule

// File: rtl/bas_offset_map.sv
module bas_offset_map
  import bas_pkg::*;
(
  input  beat_t  start_off,
  input  beat_t  beat,
  input  order_e order,
  output beat_t  off_out
);
  beat_t ilv_off;
  beat_t lin_off;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
    assign ilv_off[b] = start_off[b] ^ beat[b];
  end

  assign lin_off = start_off + beat;

  always_comb begin
    unique case (order)
      ORD_INTERLEAVE: off_out = ilv_off;
      default:        off_out = lin_off;
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bas_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic          adv_i,
  input  logic [AW-1:0] addr_i,
  input  logic          mode_i,
  output logic [AW-1:0] addr_o,
  output logic [1:0]    beat_o,
  output logic          last_o
);
  localparam int HI_W = AW - BEAT_W;

  logic [AW-1:0] start_q;
  order_e        order_q;
  beat_t         beat_q;
  beat_t         low_off;

  bas_capture #(.AW(AW)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .load    (load_i),
    .addr_in (addr_i),
    .mode_in (mode_i),
    .start_q (start_q),
    .order_q (order_q)
  );

  bas_beat_ctr u_ctr (
    .clk    (clk),
    .rst    (rst),
    .clear  (load_i),
    .step   (adv_i),
    .beat_q (beat_q)
  );

  bas_offset_map u_map (
    .start_off (start_q[BEAT_W-1:0]),
    .beat      (beat_q),
    .order     (order_q),
    .off_out   (low_off)
  );

  assign addr_o = {start_q[AW-1 -: HI_W], low_off};
  assign beat_o = beat_q;
  assign last_o = (beat_q == beat_t'(BEATS - 1));
endmodule

// File: rtl/bas_chk.sv
module bas_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst,
  input logic          load_i,
  input logic          adv_i,
  input logic [AW-1:0] addr_i,
  input logic          mode_i,
  input logic [AW-1:0] addr_o,
  input logic [1:0]    beat_o,
  input logic          last_o
);
  logic          seen_ilv;
  logic [AW-1:0] seen_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_ilv   <= 1'b1;
      seen_start <= '0;
    end else if (load_i) begin
      seen_ilv   <= mode_i;
      seen_start <= addr_i;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (addr_o == '0 && beat_o == 2'd0 && !last_o)); // R1

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (addr_o == $past(addr_i) && beat_o == 2'd0)); // R2

  AST_LOAD_BEATS_ADV: assert property (@(posedge clk) disable iff (rst)
    (load_i && adv_i) |=> beat_o == 2'd0); // R3

  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (rst)
    (adv_i && !load_i) |=> beat_o == $past(beat_o) + 2'd1); // R4

  AST_ILV_STEP: assert property (@(posedge clk) disable iff (rst)
    (adv_i && !load_i && seen_ilv) |=>
      ((addr_o[1:0] ^ $past(addr_o[1:0])) == ($past(beat_o) ^ ($past(beat_o) + 2'd1)))); // R5

  AST_LIN_STEP: assert property (@(posedge clk) disable iff (rst)
    (adv_i && !load_i && !seen_ilv) |=> addr_o[1:0] == $past(addr_o[1:0]) + 2'd1); // R6

  AST_WRAP_START: assert property (@(posedge clk) disable iff (rst)
    (adv_i && !load_i && last_o) |=> (addr_o == seen_start && beat_o == 2'd0)); // R7

  AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> addr_o[AW-1:2] == $past(addr_o[AW-1:2])); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !adv_i) |=> ($stable(addr_o) && $stable(beat_o) && $stable(last_o))); // R9
endmodule

bind burst_addr_seq bas_chk #(.AW(AW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .load_i (load_i),
  .adv_i  (adv_i),
  .addr_i (addr_i),
  .mode_i (mode_i),
  .addr_o (addr_o),
  .beat_o (beat_o),
  .last_o (last_o)
);

// File: tb/sim_burst_addr_seq.sv
`timescale 1ns/1ps
module sim_burst_addr_seq;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load_i = 1'b0;
  logic          adv_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          mode_i = 1'b1;
  logic [AW-1:0] addr_o;
  logic [1:0]    beat_o;
  logic          last_o;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #4 clk = ~clk;

  burst_addr_seq #(.AW(AW)) u0 (
    .clk(clk), .rst(rst), .load_i(load_i), .adv_i(adv_i),
    .addr_i(addr_i), .mode_i(mode_i),
    .addr_o(addr_o), .beat_o(beat_o), .last_o(last_o)
  );

  task automatic report;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not end, got %0d cycles, expected fewer", cycles);
      report();
    end
  end

  task automatic chk(input string req, input logic [AW-1:0] ea, input logic [1:0] eb);
    logic el;
    el = (eb == 2'd3);
    n_checks++;
    if (addr_o !== ea || beat_o !== eb || last_o !== el) begin
      n_fail++;
      $display("FAIL %s: addr=%h beat=%0d last=%b, expected addr=%h beat=%0d last=%b",
               req, addr_o, beat_o, last_o, ea, eb, el);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, sample at the next falling edge
  task automatic cyc(input logic ld, input logic ad, input logic [AW-1:0] a, input logic m);
    load_i = ld; adv_i = ad; addr_i = a; mode_i = m;
    @(negedge clk);
    load_i = 1'b0; adv_i = 1'b0;
  endtask

  function automatic logic [1:0] exp_off(input logic ilv, input logic [1:0] s, input logic [1:0] b);
    return ilv ? (s ^ b) : (s + b);
  endfunction

  task automatic t_reset;
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1 reset", '0, 2'd0);
    rst = 1'b0;
    cyc(1'b0, 1'b1, '0, 1'b0);
    chk("R1 default interleaved beat1", 20'h00001, 2'd1);
    cyc(1'b0, 1'b1, '0, 1'b0);
    chk("R1 default interleaved beat2", 20'h00002, 2'd2);
  endtask

  task automatic t_sweep(input logic ilv);
    for (int s = 0; s < 4; s++) begin
      logic [AW-1:0] base;
      base = {18'h2A5C3, 2'(s)} ^ {2'(s), 18'h0};
      cyc(1'b1, 1'b0, base, ilv);
      chk("R2 load", base, 2'd0);
      for (int k = 1; k <= 8; k++) begin
        logic [1:0] b;
        b = 2'(k);
        cyc(1'b0, 1'b1, '1, ~ilv);
        chk(ilv ? "R5 R7 R8 interleaved" : "R6 R7 R8 linear",
            {base[AW-1:2], exp_off(ilv, base[1:0], b)}, b);
      end
    end
  endtask

  task automatic t_priority;
    cyc(1'b1, 1'b0, 20'h12341, 1'b0);
    cyc(1'b0, 1'b1, '0, 1'b0);
    cyc(1'b0, 1'b1, '0, 1'b0);
    chk("R4 linear beat2", 20'h12343, 2'd2);
    cyc(1'b1, 1'b1, 20'hABCD2, 1'b1);
    chk("R3 load wins", 20'hABCD2, 2'd0);
  endtask

  task automatic t_idle;
    cyc(1'b1, 1'b0, 20'h55557, 1'b1);
    cyc(1'b0, 1'b1, '0, 1'b1);
    cyc(1'b0, 1'b1, '0, 1'b1);
    cyc(1'b0, 1'b1, '0, 1'b1);
    chk("R4 last beat", 20'h55554, 2'd3);
    for (int i = 0; i < 3; i++) begin
      cyc(1'b0, 1'b0, 20'hFFFFF, 1'b0);
      chk("R9 idle hold", 20'h55554, 2'd3);
    end
  endtask

  task automatic t_mode_change;
    cyc(1'b1, 1'b0, 20'h0F0F1, 1'b0);
    cyc(1'b0, 1'b1, '0, 1'b1);
    chk("R10 linear kept beat1", 20'h0F0F2, 2'd1);
    cyc(1'b0, 1'b1, '0, 1'b1);
    chk("R10 linear kept beat2", 20'h0F0F3, 2'd2);
    cyc(1'b1, 1'b0, 20'h0F0F1, 1'b1);
    cyc(1'b0, 1'b1, '0, 1'b0);
    chk("R10 interleaved kept beat1", 20'h0F0F0, 2'd1);
    cyc(1'b0, 1'b1, '0, 1'b0);
    chk("R10 interleaved kept beat2", 20'h0F0F3, 2'd2);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_sweep(1'b1);
    t_sweep(1'b0);
    t_priority();
    t_idle();
    t_mode_change();
    report();
  end
endmodule